// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that gives eight general-purpose port lines with no direction register. Each line has one latch bit. A latch bit of 1 leaves the line on its weak pull-up, so the line can be used as an input. A latch bit of 0 pulls the line low. The level seen on a line is the wired-AND of its latch bit and the external level. A line therefore reads low when either this device or the outside circuit holds it down.

All port access is a plain one-byte I2C transfer, with no command byte and no register pointer. A write transaction loads the latch; when a transaction carries several data bytes, each byte updates the port in turn. A read transaction returns the live line state. The state is sampled when each byte starts to go out, and new bytes follow until the controller answers with a NACK.

The device remembers the value the controller last read. While the observed line state differs from that value, the active-low interrupt output is held low. A read releases it. A write re-evaluates it against the new line state. SCL and SDA are oversampled on the system clock, and SDA is driven open-drain through an enable.

Top module: `i2c_qbio_expander`

## Requirements
- R1: The device acknowledges only the 7-bit address formed as binary 0100 followed by `addr_strap[2:0]` (strap bit 2 is the most significant of the three). Any other address gets no acknowledge, `sda_oe` stays 0 for the rest of that transaction, and the port is unchanged.
- R2: After a write byte is acknowledged, the latch holds that byte and `pin_pull_low` equals its bitwise inverse. Bit n of the byte controls line n, and the first bit on the bus is bit 7.
- R3: Every data byte of a multi-byte write is acknowledged and applied to the port when its acknowledge is given. The port shows each byte in turn and keeps the last one.
- R4: A read byte equals the latch ANDed with the sampled external level (`pin_level_i`). It is sent most significant bit first, with `sda_oe` = 1 for a 0 bit.
- R5: After reset, the latch, the sampled input and the last-read reference are all 0xFF. `pin_pull_low` is 0x00, `int_n` is 1 and `sda_oe` is 0.
- R6: `int_n` goes low one clock after a change on `pin_level_i` makes the line state differ from the last-read reference.
- R7: Starting each read byte loads the line state sent in that byte into the last-read reference, which releases `int_n` when the lines are then steady.
- R8: After a write, `int_n` is 1 if the new line state equals the last-read reference and 0 otherwise.
- R9: In a read, each byte is sampled when its transmission starts, so a level change during a byte shows in the next byte. The device keeps sending until the controller gives a NACK, then releases SDA.
- R10: A START or STOP at any point aborts the byte in progress. A partly received byte never reaches the latch, and a repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock level seen on the bus |
| sda_i | input | 1 | I2C data level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_strap | input | 3 | Low three bits of the target address |
| pin_level_i | input | 8 | External level on each port line |
| pin_pull_low | output | 8 | 1 pulls the corresponding port line low |
| int_n | output | 1 | Active-low change interrupt |

## Verification
Every bus edge reaches the target state machine two synchronizer clocks plus one edge-detect clock after the bench drives it. The latch and `pin_pull_low` settle one clock after the acknowledge is registered, so about four clocks after the SCL falling edge that ends a write byte. `int_n` follows a level change by one clock, through the input sampling register. The bench changes bus wires on falling clock edges and holds each bus phase for eight clocks, so it reads SDA and the port outputs only after every such latency has passed. It checks the interrupt three clocks after a level change and the port after the STOP.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/qbio_sync_detect.sv
module qbio_sync_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/qbio_target_fsm.sv
module qbio_target_fsm
  import qbio_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          ADDR_HI_W = 4,
  parameter int          STRAP_W   = 3,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [W-1:0]       line_st,
  output logic               sda_oe,
  output logic               wr_stb,
  output logic [W-1:0]       wr_data,
  output logic               rd_stb,
  output logic [W-1:0]       rd_snap
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  tgt_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     sr;
  logic [W-1:0]     tx;
  logic             rw;
  logic             nack;

  assign rd_snap = tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sr      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
      rd_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sr  <= {sr[W-2:0], sda_s};
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == FULL) begin
              if (sr[W-1:1] == {ADDR_HI, strap}) begin
                state  <= ST_ADDR_ACK;
                sda_oe <= 1'b1;
                rw     <= sr[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                state  <= ST_RD;
                tx     <= line_st;
                rd_stb <= 1'b1;
                sda_oe <= ~line_st[W-1];
              end else begin
                state  <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sr  <= {sr[W-2:0], sda_s};
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == FULL) begin
              wr_stb  <= 1'b1;
              wr_data <= sr;
              sda_oe  <= 1'b1;
              state   <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                tx     <= tx << 1;
                sda_oe <= ~tx[W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (nack) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end else begin
                state  <= ST_RD;
                tx     <= line_st;
                rd_stb <= 1'b1;
                sda_oe <= ~line_st[W-1];
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_level_i,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         rd_stb,
  input  logic [W-1:0] rd_snap,
  output logic [W-1:0] line_st,
  output logic [W-1:0] line_ref,
  output logic [W-1:0] pin_pull_low,
  output logic         int_n
);
  logic [W-1:0] latch_q, in_q, ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      in_q    <= '1;
      ref_q   <= '1;
    end else begin
      in_q <= pin_level_i;
      if (wr_stb) latch_q <= wr_data;
      if (rd_stb) ref_q   <= rd_snap;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    assign line_st[i]      = latch_q[i] & in_q[i];
    assign pin_pull_low[i] = ~latch_q[i];
  end

  assign line_ref = ref_q;
  assign int_n    = (line_st == ref_q);
endmodule

// File: rtl/i2c_qbio_expander.sv
module i2c_qbio_expander #(
  parameter int                   NPORT     = 8,
  parameter int                   STRAP_W   = 3,
  parameter int                   ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI   = 4'b0100,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [NPORT-1:0]   pin_level_i,
  output logic [NPORT-1:0]   pin_pull_low,
  output logic               int_n
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_stb, rd_stb;
  logic [NPORT-1:0] wr_data, rd_snap, line_st, line_ref;

  qbio_sync_detect #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  qbio_target_fsm #(
    .W(NPORT), .ADDR_HI_W(ADDR_HI_W), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(addr_strap), .line_st(line_st), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_snap(rd_snap)
  );

  qbio_port #(.W(NPORT)) u_port (
    .clk(clk), .rst_n(rst_n), .pin_level_i(pin_level_i),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_snap(rd_snap),
    .line_st(line_st), .line_ref(line_ref), .pin_pull_low(pin_pull_low),
    .int_n(int_n)
  );
endmodule

// File: rtl/qbio_checker.sv
module qbio_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         sda_oe,
  input logic         stop_det,
  input logic         wr_stb,
  input logic         rd_stb,
  input logic [W-1:0] line_st,
  input logic [W-1:0] pin_pull_low,
  input logic         int_n
);
  // R2: port drive moves only right after an accepted write byte
  p_drive_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> $stable(pin_pull_low));

  // R1: SDA drive is only taken up while SCL is low
  p_sda_take_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R10: a STOP leaves SDA released
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe);

  // R9: a byte is never both written and read
  p_one_direction_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));

  // R7: interrupt release needs a read, a write or a line change
  p_int_release_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> ($past(rd_stb) || $past(wr_stb) || !$stable(line_st)));

  // R6: interrupt assertion needs a line change or a new reference
  p_int_assert_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> (!$stable(line_st) || $past(rd_stb) || $past(wr_stb)));
endmodule

bind i2c_qbio_expander qbio_checker #(.W(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .stop_det(stop_det), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .line_st(line_st), .pin_pull_low(pin_pull_low), .int_n(int_n)
);

// File: tb/tb_i2c_qbio_expander.sv
module tb_i2c_qbio_expander;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] DEV_ADDR = 7'b0100_101;
  // {write byte, external level, expected read}
  localparam logic [23:0] VEC [6] = '{
    24'hFF_A5_A5, 24'h0F_FF_0F, 24'hF0_3C_30,
    24'h00_FF_00, 24'h55_AA_00, 24'hC3_E7_C3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] level = 8'hFF;
  logic sda_oe, int_n;
  logic [7:0] pull_low;
  wire sda_bus = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_err = 0;
  logic ack;
  logic [7:0] rd;
  logic b;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_qbio_expander dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(strap), .pin_level_i(level), .pin_pull_low(pull_low),
    .int_n(int_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic wbit(input logic v);
    sda_m = v; wclk(Q); scl_m = 1'b1; wclk(2*Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic rbit(output logic v);
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    v = sda_bus; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic a);
    logic nb;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(nb);
    a = ~nb;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic give_nack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      rbit(v);
      d[i] = v;
    end
    wbit(give_nack);
  endtask

  task automatic do_write(input logic [6:0] a7, input logic [7:0] d, output logic a);
    logic a1;
    i2c_start();
    wbyte({a7, 1'b0}, a1);
    wbyte(d, a);
    a = a & a1;
    i2c_stop();
  endtask

  task automatic do_read(output logic [7:0] d);
    logic a1;
    i2c_start();
    wbyte({DEV_ADDR, 1'b1}, a1);
    rbyte(d, 1'b1);
    i2c_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin : main
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    // R5: reset state
    check("R5 pull_low", {24'd0, pull_low}, 32'h00);
    check("R5 int_n", {31'd0, int_n}, 32'd1);
    check("R5 sda_oe", {31'd0, sda_oe}, 32'd0);
    do_read(rd);
    check("R5 read after reset", {24'd0, rd}, 32'hFF);

    // R2 / R4: vector table
    for (int i = 0; i < 6; i++) begin
      level = VEC[i][15:8];
      do_write(DEV_ADDR, VEC[i][23:16], ack);
      check("R2 ack", {31'd0, ack}, 32'd1);
      check("R2 pull_low", {24'd0, pull_low}, {24'd0, ~VEC[i][23:16]});
      do_read(rd);
      check("R4 read", {24'd0, rd}, {24'd0, VEC[i][7:0]});
    end

    // R1: wrong addresses are not acknowledged and leave the port alone
    level = 8'hFF;
    do_write(DEV_ADDR, 8'hFF, ack);
    do_write(7'b0100_100, 8'h00, ack);
    check("R1 nack low bit", {31'd0, ack}, 32'd0);
    check("R1 port kept", {24'd0, pull_low}, 32'h00);
    strap = 3'b001;
    do_write(7'b0100_101, 8'h00, ack);
    check("R1 nack old strap", {31'd0, ack}, 32'd0);
    do_write(7'b0100_001, 8'h7E, ack);
    check("R1 ack new strap", {31'd0, ack}, 32'd1);
    check("R1 port new strap", {24'd0, pull_low}, 32'h81);
    strap = 3'b101;
    do_write(DEV_ADDR, 8'hFF, ack);

    // R6 / R7 / R8: interrupt flow
    do_read(rd);
    check("R7 int released", {31'd0, int_n}, 32'd1);
    level = 8'hF0;
    wclk(3);
    check("R6 int on change", {31'd0, int_n}, 32'd0);
    do_read(rd);
    check("R4 read F0", {24'd0, rd}, 32'hF0);
    check("R7 int cleared by read", {31'd0, int_n}, 32'd1);
    do_write(DEV_ADDR, 8'h0F, ack);
    check("R8 int after differing write", {31'd0, int_n}, 32'd0);
    do_write(DEV_ADDR, 8'hFF, ack);
    check("R8 int after matching write", {31'd0, int_n}, 32'd1);

    // R3: multi-byte write
    level = 8'hFF;
    i2c_start();
    wbyte({DEV_ADDR, 1'b0}, ack);
    wbyte(8'h12, ack);
    check("R3 ack byte1", {31'd0, ack}, 32'd1);
    check("R3 port byte1", {24'd0, pull_low}, 32'hED);
    wbyte(8'h34, ack);
    check("R3 ack byte2", {31'd0, ack}, 32'd1);
    i2c_stop();
    check("R3 port last", {24'd0, pull_low}, 32'hCB);

    // R9: multi-byte read, level changes mid byte
    do_write(DEV_ADDR, 8'hFF, ack);
    do_read(rd);
    i2c_start();
    wbyte({DEV_ADDR, 1'b1}, ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 3) level = 8'h5A;
      rbit(b);
      rd[i] = b;
    end
    wbit(1'b0);
    check("R9 first byte old level", {24'd0, rd}, 32'hFF);
    rbyte(rd, 1'b1);
    check("R9 second byte new level", {24'd0, rd}, 32'h5A);
    check("R9 released after nack", {31'd0, sda_oe}, 32'd0);
    i2c_stop();
    check("R7 int after multi read", {31'd0, int_n}, 32'd1);

    // R10: aborted byte and repeated start
    level = 8'hFF;
    do_write(DEV_ADDR, 8'hFF, ack);
    i2c_start();
    wbyte({DEV_ADDR, 1'b0}, ack);
    wbit(1'b0); wbit(1'b0); wbit(1'b0); wbit(1'b0);
    i2c_stop();
    check("R10 partial byte dropped", {24'd0, pull_low}, 32'h00);
    i2c_start();
    wbyte({DEV_ADDR, 1'b0}, ack);
    wbyte(8'h3C, ack);
    i2c_start();
    wbyte({DEV_ADDR, 1'b1}, ack);
    check("R10 ack after repeated start", {31'd0, ack}, 32'd1);
    rbyte(rd, 1'b1);
    i2c_stop();
    check("R10 read after repeated start", {24'd0, rd}, 32'h3C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule